// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

A purely combinational integer unit for a 32-bit RISC execute stage. Each cycle it receives a 4-bit operation code, a set-flags bit, the destination register index, a first operand, a second operand that has already passed through the barrel shifter, the shifter's carry-out, and the current N, Z, C and V condition flags. It returns the operation result, a destination write enable, the next condition flags, and a request to restore the status word from its saved copy.

Bitwise operations take their carry flag from the shifter and keep V. Add and subtract operations produce carry and overflow from the adder. Add-with-carry, subtract-with-carry and reverse-subtract-with-carry use the incoming C flag. The four test and compare operations only update the flags and never write a register. If a register-writing operation sets flags and its destination is the program counter, the flags are not recomputed. The unit raises the restore request instead, so that the surrounding core can return from an exception.

Top module: `dpalu_top`

## Requirements
- R1: Bitwise opcodes give these results: 0 = A AND B, 1 = A XOR B, 12 = A OR B, 13 = B, 14 = A AND NOT B, 15 = NOT B. Test opcodes 8 and 9 show A AND B and A XOR B on `result`.
- R2: Arithmetic opcodes give these results modulo 2^32: 4 = A+B, 2 = A-B, 3 = B-A, 5 = A+B+C, 6 = A-B-(1-C), 7 = B-A-(1-C). C is the incoming carry flag. Compare opcodes 10 and 11 show A-B and A+B on `result`.
- R3: `writeEn` is 0 for opcodes 8 to 11 and 1 for every other opcode, whatever the set-flags bit is.
- R4: The flag vectors are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. For a bitwise opcode (0, 1, 8, 9, 12 to 15) with flags updated: N is result bit 31, Z is 1 exactly when the result is zero, C equals `shiftCarry`, and V keeps its input value.
- R5: For an arithmetic opcode with flags updated, C is set under these conditions. Additions: the true sum exceeds 2^32-1. Subtractions: the minuend is at least the subtrahend plus the borrow-in, so that no borrow occurs. N and Z follow the result as in R4.
- R6: For an arithmetic opcode with flags updated, V is 1 exactly when the signed two's-complement result of the operation is outside the range -2^31 to 2^31-1.
- R7: With `setFlags` = 0, `flagsOut` equals `flagsIn` for every opcode.
- R8: Take a register-writing opcode with `setFlags` = 1 and `dstIdx` = 15. `restoreStatus` is 1 and `flagsOut` equals `flagsIn`. In every other case `restoreStatus` is 0. For opcodes 8 to 11, `dstIdx` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation code, 0 to 15 |
| setFlags | input | 1 | Update condition flags |
| dstIdx | input | 4 | Destination register index |
| opA | input | 32 | First operand |
| opB | input | 32 | Shifted second operand |
| shiftCarry | input | 1 | Carry-out of the barrel shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Destination register write enable |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |
| restoreStatus | output | 1 | Request to restore status from its saved copy |

## Verification
The unit holds no state, so a fault in its decode strobes or carry-in selection shows on the ports in the same cycle as the stimulus. One wrong strobe can give a bad result, a spurious write enable, a misrouted carry, or a V flag that is lost. The sweep covers every opcode, both settings of the set-flags bit, and both an ordinary destination and the program counter as destination. It uses operands at the signed and unsigned boundaries and all carry and overflow input combinations, so each such fault shows up on at least one vector.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {LG_AND, LG_XOR, LG_OR, LG_PASS} logic_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic   isArith;
    logic_e logicSel;
    logic   invA;
    logic   invB;
    cin_e   cinSel;
    logic   writesDest;
  } strobes_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dpalu_ctrl.sv
module dpalu_ctrl
  import dpalu_pkg::*;
(
  input  logic [3:0] opcode,
  output strobes_t   strobes
);

  always_comb begin
    strobes = '{isArith: 1'b0, logicSel: LG_AND, invA: 1'b0, invB: 1'b0,
                cinSel: CIN_ZERO, writesDest: 1'b1};
    unique case (opcode_e'(opcode))
      OP_AND: strobes.logicSel = LG_AND;
      OP_EOR: strobes.logicSel = LG_XOR;
      OP_TST: begin strobes.logicSel = LG_AND; strobes.writesDest = 1'b0; end
      OP_TEQ: begin strobes.logicSel = LG_XOR; strobes.writesDest = 1'b0; end
      OP_ORR: strobes.logicSel = LG_OR;
      OP_MOV: strobes.logicSel = LG_PASS;
      OP_BIC: begin strobes.logicSel = LG_AND;  strobes.invB = 1'b1; end
      OP_MVN: begin strobes.logicSel = LG_PASS; strobes.invB = 1'b1; end
      OP_ADD: strobes.isArith = 1'b1;
      OP_ADC: begin strobes.isArith = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_SUB: begin strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_ONE; end
      OP_SBC: begin strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_RSB: begin strobes.isArith = 1'b1; strobes.invA = 1'b1; strobes.cinSel = CIN_ONE; end
      OP_RSC: begin strobes.isArith = 1'b1; strobes.invA = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_CMP: begin strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_ONE;
                    strobes.writesDest = 1'b0; end
      OP_CMN: begin strobes.isArith = 1'b1; strobes.writesDest = 1'b0; end
      default: ;
    endcase
  end

  // R3: test and compare codes sit in 8..11 and never write
  always_comb begin
    assert_cmp_no_write_R3: assert (!(opcode[3:2] == 2'b10) || !strobes.writesDest)
      else $error("compare opcode decoded as writing");
  end

endmodule

// File: rtl/dpalu_core.sv
module dpalu_core
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  strobes_t          strobes,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryFlag,
  input  logic              overflowFlag,
  input  logic              shiftCarry,
  output logic [WIDTH-1:0]  result,
  output logic [3:0]        calcFlags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addX, addY, logicRes, sumRes;
  logic [WIDTH:0]   sumFull;
  logic             carryIn, sumOverflow;

  assign addX = strobes.invA ? ~opA : opA;
  assign addY = strobes.invB ? ~opB : opB;

  always_comb begin
    unique case (strobes.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = carryFlag;
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumFull     = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, carryIn};
  assign sumRes      = sumFull[MSB:0];
  assign sumOverflow = ~(addX[MSB] ^ addY[MSB]) & (addX[MSB] ^ sumRes[MSB]);

  always_comb begin
    unique case (strobes.logicSel)
      LG_AND:  logicRes = opA & addY;
      LG_XOR:  logicRes = opA ^ addY;
      LG_OR:   logicRes = opA | addY;
      default: logicRes = addY;
    endcase
  end

  assign result = strobes.isArith ? sumRes : logicRes;

  always_comb begin
    calcFlags[FLAG_N] = result[MSB];
    calcFlags[FLAG_Z] = (result == '0);
    calcFlags[FLAG_C] = strobes.isArith ? sumFull[WIDTH] : shiftCarry;
    calcFlags[FLAG_V] = strobes.isArith ? sumOverflow : overflowFlag;
  end

  // R5: a plain subtract carries exactly when no borrow occurs
  always_comb begin
    assert_sub_carry_R5: assert (!(strobes.isArith && strobes.invB && !strobes.invA &&
                                   strobes.cinSel == CIN_ONE) ||
                                 (sumFull[WIDTH] == (opA >= opB)))
      else $error("subtract carry disagrees with operand compare");
  end

endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
  import dpalu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int REG_BITS = 4,
  parameter int PC_INDEX = 15
) (
  input  logic [3:0]          opcode,
  input  logic                setFlags,
  input  logic [REG_BITS-1:0] dstIdx,
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic                shiftCarry,
  input  logic [3:0]          flagsIn,
  output logic [WIDTH-1:0]    result,
  output logic                writeEn,
  output logic [3:0]          flagsOut,
  output logic                restoreStatus
);

  strobes_t   strobes;
  logic [3:0] calcFlags;
  logic       dstIsPc;

  dpalu_ctrl u_ctrl (
    .opcode (opcode),
    .strobes(strobes)
  );

  dpalu_core #(.WIDTH(WIDTH)) u_core (
    .strobes     (strobes),
    .opA         (opA),
    .opB         (opB),
    .carryFlag   (flagsIn[FLAG_C]),
    .overflowFlag(flagsIn[FLAG_V]),
    .shiftCarry  (shiftCarry),
    .result      (result),
    .calcFlags   (calcFlags)
  );

  assign dstIsPc       = (dstIdx == REG_BITS'(PC_INDEX));
  assign writeEn       = strobes.writesDest;
  assign restoreStatus = setFlags && strobes.writesDest && dstIsPc;
  assign flagsOut      = (setFlags && !restoreStatus) ? calcFlags : flagsIn;

  always_comb begin
    assert_hold_flags_R7: assert (setFlags || flagsOut == flagsIn)
      else $error("flags changed with set-flags clear");
    assert_restore_keeps_flags_R8: assert (!restoreStatus || flagsOut == flagsIn)
      else $error("flags recomputed during restore");
    assert_restore_needs_write_R8: assert (!restoreStatus || writeEn)
      else $error("restore requested by non-writing opcode");
    assert_logic_keeps_v_R4: assert (strobes.isArith || flagsOut[FLAG_V] == flagsIn[FLAG_V])
      else $error("bitwise opcode altered V");
  end

endmodule

// File: tb/dpalu_top_test.sv
module dpalu_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic [3:0]  dstIdx = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] result;
  logic        writeEn, restoreStatus;
  logic [3:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpalu_top uut (
    .opcode(opcode), .setFlags(setFlags), .dstIdx(dstIdx), .opA(opA), .opB(opB),
    .shiftCarry(shiftCarry), .flagsIn(flagsIn), .result(result), .writeEn(writeEn),
    .flagsOut(flagsOut), .restoreStatus(restoreStatus)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d S=%0d dst=%0d a=%h b=%h f=%b sc=%b actual=%h expected=%h",
               req, opcode, setFlags, dstIdx, opA, opB, flagsIn, shiftCarry, act, exp);
    end
  endtask

  function automatic longint sx(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  task automatic run_case();
    longint ua, ub, c, nc, full, sres;
    logic [31:0] expRes;
    logic [3:0]  expFlags;
    bit arith, writes, restore, cOut, vOut;
    ua = longint'(opA); ub = longint'(opB);
    c = longint'(flagsIn[1]); nc = 1 - c;
    arith = 1; full = 0; sres = 0; expRes = '0;
    case (opcode)
      0, 8:  begin arith = 0; expRes = opA & opB; end                         // R1
      1, 9:  begin arith = 0; expRes = opA ^ opB; end                         // R1
      12:    begin arith = 0; expRes = opA | opB; end
      13:    begin arith = 0; expRes = opB; end
      14:    begin arith = 0; expRes = opA & ~opB; end
      15:    begin arith = 0; expRes = ~opB; end
      4, 11: begin full = ua + ub;       sres = sx(opA) + sx(opB); end        // R2
      5:     begin full = ua + ub + c;   sres = sx(opA) + sx(opB) + c; end
      2, 10: begin full = ua - ub;       sres = sx(opA) - sx(opB); end
      6:     begin full = ua - ub - nc;  sres = sx(opA) - sx(opB) - nc; end
      3:     begin full = ub - ua;       sres = sx(opB) - sx(opA); end
      default: begin full = ub - ua - nc; sres = sx(opB) - sx(opA) - nc; end
    endcase
    if (arith) expRes = full[31:0];
    // carry: add wraps past 2^32-1; subtract gives no borrow (full >= 0)
    if (opcode inside {4, 5, 11}) cOut = (full > 64'sh0_FFFF_FFFF);
    else cOut = (full >= 0);
    vOut = (sres > 64'sh7FFF_FFFF) || (sres < -64'sh8000_0000);
    writes = !(opcode inside {8, 9, 10, 11});
    restore = setFlags && writes && (dstIdx == 4'd15);
    if (!setFlags || restore) expFlags = flagsIn;
    else if (arith) expFlags = {expRes[31], expRes == 0, cOut, vOut};
    else expFlags = {expRes[31], expRes == 0, shiftCarry, flagsIn[0]};

    @(posedge clk); #1;
    check(result == expRes, arith ? "R2 result" : "R1 result", longint'(result), longint'(expRes));
    check(writeEn == writes, "R3 writeEn", longint'(writeEn), longint'(writes));
    check(restoreStatus == restore, "R8 restoreStatus", longint'(restoreStatus), longint'(restore));
    if (!setFlags)
      check(flagsOut == expFlags, "R7 flags held", longint'(flagsOut), longint'(expFlags));
    else if (restore)
      check(flagsOut == expFlags, "R8 flags held on restore", longint'(flagsOut), longint'(expFlags));
    else if (!arith)
      check(flagsOut == expFlags, "R4 logic flags", longint'(flagsOut), longint'(expFlags));
    else begin
      check(flagsOut[3:1] == expFlags[3:1], "R5 arith NZC", longint'(flagsOut[3:1]), longint'(expFlags[3:1]));
      check(flagsOut[0] == expFlags[0], "R6 overflow V", longint'(flagsOut[0]), longint'(expFlags[0]));
    end
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stimulus
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;
    // idle vector: all-zero inputs
    @(negedge clk);
    run_case();
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
              for (int fc = 0; fc < 4; fc++) begin
                @(negedge clk);
                opcode = 4'(op); setFlags = s[0]; dstIdx = d[0] ? 4'd15 : 4'd3;
                opA = pats[i]; opB = pats[j];
                flagsIn = {i[0], j[0], fc[1], fc[0]};
                shiftCarry = fc[0] ^ i[1];
                run_case();
              end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule